// File: doc/BRIEF.md
# Multi-Lane Marker Deskew Aligner

This block takes parallel words from several received serial links and lines them up in time. Each link can arrive with a different latency, for instance because its fibre is longer or shorter than the others. A user-defined marker word, such as a bunch-zero word or a start-of-packet word, travels on every link. The block uses the marker to measure the skew between links. It then delays each lane just enough to match the latest lane, so the marker leaves on the same output cycle on every lane. The slowest link gets the least delay, which keeps the added latency as small as possible.

A sync master starts an alignment by pulsing `sync_req` while `enable` is high. The block records the cycle on which the marker first arrives on each selected lane and derives every lane's delay from those cycles. It then raises `sync_done` toward slave units and keeps it high. The block raises an error instead when the spread between lanes is too large for the delay lines, or when a selected lane shows no marker in time. While aligned, the block keeps watching the outputs and raises a sticky flag if the markers stop coinciding.

The links cannot be stalled, so there is no ready signal on either side. Each input word is accepted on the cycle its valid bit is high. Each output word is valid only on the cycle `out_valid` shows it, and the consumer must take it on that cycle.

Top module: `lane_deskew_aligner`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `sync_done`, `align_err`, `lost_align` and every `out_valid` bit are low.
- R2: A `sync_req` sampled with `enable` high starts a new alignment, and `sync_done` stays low until it completes. One cycle after `enable` is sampled low, `sync_done` and `align_err` are low.
- R3: After alignment, every selected lane presents the same stream word on the same cycle, with `out_valid` high. The latest lane is delayed by one register stage, and a lane that sees its marker k cycles earlier gets k extra stages. `out_valid` is never high unless `sync_done` is high.
- R4: A lane word counts as a marker only when that lane's valid bit is high and `(word & marker_mask) == marker_value`.
- R5: If the latest and earliest marker arrivals on selected lanes differ by more than DEPTH-1 cycles, `align_err` rises and `sync_done` stays low. A spread of exactly DEPTH-1 still aligns. `sync_done` and `align_err` are never high together.
- R6: If any selected lane has shown no marker after TIMEOUT cycles of waiting, `align_err` rises. It stays high until a new `sync_req` arrives or `enable` drops.
- R7: While aligned, if some selected lanes show a marker at the output and others do not on the same cycle, `lost_align` rises. It stays high while aligned, without dropping `sync_done`, until a new `sync_req` arrives or `enable` drops.
- R8: Lanes whose `lane_en` bit is low when `sync_req` is sampled are ignored. No marker is awaited on them, their skew has no effect, and their `out_valid` stays low.
- R9: A `sync_req` in the aligned or error state restarts alignment. On the next cycle `sync_done`, `align_err` and `lost_align` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Block enable; low returns to idle |
| sync_req | input | 1 | Pulse from the sync master that starts an alignment |
| lane_en | input | NUM_LANES | Lanes taking part, captured on `sync_req` |
| marker_mask | input | DATA_W | Bits compared when looking for the marker |
| marker_value | input | DATA_W | Marker value under the mask |
| in_data | input | NUM_LANES*DATA_W | Received words, lane i at bits [i*DATA_W +: DATA_W] |
| in_valid | input | NUM_LANES | Per-lane word valid |
| out_data | output | NUM_LANES*DATA_W | Aligned words, same packing as `in_data` |
| out_valid | output | NUM_LANES | Per-lane aligned word valid |
| sync_done | output | 1 | Alignment complete, toward slave units |
| align_err | output | 1 | Alignment failed: spread too large or timeout |
| lost_align | output | 1 | Sticky flag: output markers no longer coincide |

## Verification
The assertions check on every cycle the relations between the status flags. They confirm that done and error are exclusive, that valid outputs appear only while aligned, and that the error and loss flags stay set. They also confirm that a request or a dropped enable clears everything. Only the bench's scenarios can show that the delays are correct: that every selected lane delivers the same stream word at the expected latency for a given set of skews. The same holds for the limit cases: the exact DEPTH-1 spread, the too-wide spread, a missing marker, a mask that rejects the marker, and an ignored lane with a large skew.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_ALIGNED = 2'd2,
    ST_ERROR   = 2'd3
  } align_state_t;
endpackage

// File: rtl/deskew_marker_match.sv
module deskew_marker_match #(
  parameter int DATA_W = 16
) (
  input  logic              valid,
  input  logic [DATA_W-1:0] word,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] value,
  output logic              hit
);
  // R4: a marker needs a valid word whose masked bits equal the value
  assign hit = valid && ((word & mask) == value);
endmodule

// File: rtl/deskew_delay_line.sv
module deskew_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     in_valid,
  input  logic [$clog2(DEPTH)-1:0] tap_sel,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_valid
);
  localparam int EW = DATA_W + 1;

  logic [EW-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
    end else begin
      stage[0] <= {in_valid, in_data};
      for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
    end
  end

  assign {out_valid, out_data} = stage[tap_sel];
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int DEPTH     = 16,
  parameter int TIMEOUT   = 128
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enable,
  input  logic                           sync_req,
  input  logic [NUM_LANES-1:0]           lane_en,
  input  logic [NUM_LANES-1:0]           in_hit,
  output align_state_t                   state,
  output logic [NUM_LANES-1:0]           lane_used,
  output logic [NUM_LANES*$clog2(DEPTH)-1:0] tap_sel
);
  localparam int DW = $clog2(DEPTH);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0]        wait_cnt;
  logic [CW-1:0]        arrival [NUM_LANES];
  logic [NUM_LANES-1:0] seen;

  logic          all_seen;
  logic          any_used;
  logic [CW-1:0] newest;
  logic [CW-1:0] oldest;
  logic [CW-1:0] spread;
  logic          too_wide;

  always_comb begin
    all_seen = 1'b1;
    any_used = 1'b0;
    newest   = '0;
    oldest   = '1;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (lane_used[i]) begin
        any_used = 1'b1;
        if (!seen[i]) all_seen = 1'b0;
        if (arrival[i] > newest) newest = arrival[i];
        if (arrival[i] < oldest) oldest = arrival[i];
      end
    end
    spread   = any_used ? (newest - oldest) : '0;
    too_wide = spread > CW'(DEPTH - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      wait_cnt  <= '0;
      seen      <= '0;
      lane_used <= '0;
      tap_sel   <= '0;
      for (int i = 0; i < NUM_LANES; i++) arrival[i] <= '0;
    end else if (!enable) begin
      state <= ST_IDLE;
      seen  <= '0;
    end else if (sync_req) begin
      state     <= ST_WAIT;
      wait_cnt  <= '0;
      seen      <= '0;
      lane_used <= lane_en;
    end else if (state == ST_WAIT) begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (lane_used[i] && in_hit[i] && !seen[i]) begin
          seen[i]    <= 1'b1;
          arrival[i] <= wait_cnt;
        end
      end
      if (all_seen) begin
        if (too_wide) begin
          state <= ST_ERROR;
        end else begin
          state <= ST_ALIGNED;
          for (int i = 0; i < NUM_LANES; i++)
            tap_sel[i*DW +: DW] <= DW'(newest - arrival[i]);
        end
      end else if (wait_cnt == CW'(TIMEOUT)) begin
        state <= ST_ERROR;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_deskew_aligner.sv
module lane_deskew_aligner
  import deskew_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int DATA_W    = 16,
  parameter int DEPTH     = 16,
  parameter int TIMEOUT   = 128
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          enable,
  input  logic                          sync_req,
  input  logic [NUM_LANES-1:0]          lane_en,
  input  logic [DATA_W-1:0]             marker_mask,
  input  logic [DATA_W-1:0]             marker_value,
  input  logic [NUM_LANES*DATA_W-1:0]   in_data,
  input  logic [NUM_LANES-1:0]          in_valid,
  output logic [NUM_LANES*DATA_W-1:0]   out_data,
  output logic [NUM_LANES-1:0]          out_valid,
  output logic                          sync_done,
  output logic                          align_err,
  output logic                          lost_align
);
  localparam int DW = $clog2(DEPTH);

  align_state_t               state;
  logic [NUM_LANES-1:0]       lane_used;
  logic [NUM_LANES*DW-1:0]    tap_sel;
  logic [NUM_LANES-1:0]       in_hit;
  logic [NUM_LANES-1:0]       tap_valid;
  logic [NUM_LANES-1:0]       out_hit;
  logic                       aligned;

  assign aligned = (state == ST_ALIGNED);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    deskew_marker_match #(.DATA_W(DATA_W)) u_in_match (
      .valid (in_valid[g]),
      .word  (in_data[g*DATA_W +: DATA_W]),
      .mask  (marker_mask),
      .value (marker_value),
      .hit   (in_hit[g])
    );

    deskew_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_delay (
      .clk       (clk),
      .rst       (rst),
      .in_data   (in_data[g*DATA_W +: DATA_W]),
      .in_valid  (in_valid[g]),
      .tap_sel   (tap_sel[g*DW +: DW]),
      .out_data  (out_data[g*DATA_W +: DATA_W]),
      .out_valid (tap_valid[g])
    );

    assign out_valid[g] = tap_valid[g] & lane_used[g] & aligned;

    deskew_marker_match #(.DATA_W(DATA_W)) u_out_match (
      .valid (out_valid[g]),
      .word  (out_data[g*DATA_W +: DATA_W]),
      .mask  (marker_mask),
      .value (marker_value),
      .hit   (out_hit[g])
    );
  end

  deskew_ctrl #(
    .NUM_LANES (NUM_LANES),
    .DEPTH     (DEPTH),
    .TIMEOUT   (TIMEOUT)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .sync_req  (sync_req),
    .lane_en   (lane_en),
    .in_hit    (in_hit),
    .state     (state),
    .lane_used (lane_used),
    .tap_sel   (tap_sel)
  );

  // R7: sticky watch for output markers that no longer coincide
  always_ff @(posedge clk) begin
    if (rst || !enable || sync_req) begin
      lost_align <= 1'b0;
    end else if (aligned && (|out_hit) && (out_hit != lane_used)) begin
      lost_align <= 1'b1;
    end
  end

  assign sync_done = aligned;
  assign align_err = (state == ST_ERROR);
endmodule

// File: rtl/deskew_aligner_checks.sv
module deskew_aligner_checks #(
  parameter int NUM_LANES = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 enable,
  input logic                 sync_req,
  input logic [NUM_LANES-1:0] out_valid,
  input logic                 sync_done,
  input logic                 align_err,
  input logic                 lost_align
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!sync_done && !align_err && !lost_align && out_valid == '0));

  assert_enable_drop_R2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sync_done && !align_err));

  assert_valid_needs_done_R3: assert property (@(posedge clk) disable iff (rst)
    (|out_valid) |-> sync_done);

  assert_done_err_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(sync_done && align_err));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (align_err && enable && !sync_req) |=> align_err);

  assert_lost_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (lost_align && enable && !sync_req) |=> lost_align);

  assert_lost_only_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    lost_align |-> sync_done);

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && sync_req) |=> (!sync_done && !align_err && !lost_align));
endmodule

bind lane_deskew_aligner deskew_aligner_checks #(.NUM_LANES(NUM_LANES)) u_checks (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .sync_req   (sync_req),
  .out_valid  (out_valid),
  .sync_done  (sync_done),
  .align_err  (align_err),
  .lost_align (lost_align)
);

// File: tb/lane_deskew_aligner_test.sv
`timescale 1ns/1ps
module lane_deskew_aligner_test;
  localparam int N   = 8;
  localparam int W   = 16;
  localparam int DEP = 16;
  localparam int TMO = 128;
  localparam int PER = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic           rst, enable, sync_req;
  logic [N-1:0]   lane_en, lane_live;
  logic [W-1:0]   mmask, mval;
  logic [N*W-1:0] in_data, out_data;
  logic [N-1:0]   in_valid, out_valid;
  logic           sync_done, align_err, lost_align;

  int cyc = 0;
  int skew [N];
  int checks = 0;
  int fails  = 0;

  lane_deskew_aligner #(.NUM_LANES(N), .DATA_W(W), .DEPTH(DEP), .TIMEOUT(TMO)) uut (
    .clk(clk), .rst(rst), .enable(enable), .sync_req(sync_req), .lane_en(lane_en),
    .marker_mask(mmask), .marker_value(mval), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .sync_done(sync_done),
    .align_err(align_err), .lost_align(lost_align));

  // stream word n: marker 0xBCxx every PER words, other high bytes stay below 100
  function automatic logic [W-1:0] word(int n);
    if (n < 0) return 16'h0000;
    if (n % PER == 0) return {8'hBC, 8'(n / PER)};
    return {8'(n % 100), 8'(n * 7)};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      in_data[i*W +: W] = word(cyc - skew[i]);
      in_valid[i]       = lane_live[i];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
  end

  // sync sampled at an edge with cyc%PER==38, so every lane's next marker is the same one
  task automatic start_sync();
    while ((cyc % PER) != 38) @(negedge clk);
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  task automatic check_aligned(input string req);
    int maxs = 0;
    logic bad;
    for (int i = 0; i < N; i++) if (lane_en[i] && skew[i] > maxs) maxs = skew[i];
    check(sync_done === 1'b1 && align_err === 1'b0, req, {sync_done, align_err}, 2'b10);
    for (int t = 0; t < 40; t++) begin
      bad = 1'b0;
      for (int i = 0; i < N; i++) begin
        if (lane_en[i]) begin
          if (out_valid[i] !== 1'b1 || out_data[i*W +: W] !== word(cyc - 1 - maxs)) bad = 1'b1;
        end else if (out_valid[i] !== 1'b0) bad = 1'b1;
      end
      check(!bad, req, out_data[31:0], word(cyc - 1 - maxs));
      @(negedge clk);
    end
    check(lost_align === 1'b0, req, lost_align, 0);
  endtask

  task automatic run_good(input string req);
    start_sync();
    check(sync_done === 1'b0 && align_err === 1'b0, "R9", {sync_done, align_err}, 0);
    settle();
    check_aligned(req);
  endtask

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'd7321);
    rst = 1'b1; enable = 1'b0; sync_req = 1'b0;
    lane_en = '0; lane_live = '1;
    mmask = 16'hFF00; mval = 16'hBC00;
    for (int i = 0; i < N; i++) skew[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sync_done === 1'b0 && align_err === 1'b0 && lost_align === 1'b0 && out_valid === '0,
          "R1", {sync_done, align_err, lost_align}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sync_done === 1'b0 && out_valid === '0, "R1", {sync_done, out_valid}, 0);

    // R3 + R5 boundary: spread exactly DEPTH-1 aligns
    enable = 1'b1; lane_en = '1;
    skew = '{0, 3, 7, 15, 1, 9, 12, 5};
    start_sync();
    check(sync_done === 1'b0, "R2", sync_done, 0);
    settle();
    check_aligned("R3");

    // R7: one lane slips by two words
    skew[3] = 13;
    repeat (80) @(negedge clk);
    check(lost_align === 1'b1 && sync_done === 1'b1, "R7", {lost_align, sync_done}, 2'b11);

    // R2: dropping enable clears the done flag
    enable = 1'b0;
    @(negedge clk);
    check(sync_done === 1'b0 && lost_align === 1'b0, "R2", {sync_done, lost_align}, 0);
    enable = 1'b1;

    // R4: a mask that makes the marker unmatched leads to a timeout error
    mmask = 16'hFFFF;
    start_sync();
    repeat (TMO + 10) @(negedge clk);
    check(align_err === 1'b1 && sync_done === 1'b0, "R4", {align_err, sync_done}, 2'b10);
    mmask = 16'hFF00;

    // R5: spread beyond DEPTH-1
    skew = '{0, 20, 4, 4, 4, 4, 4, 4};
    start_sync();
    settle();
    check(align_err === 1'b1 && sync_done === 1'b0, "R5", {align_err, sync_done}, 2'b10);

    // R9: recovery from error with a new request
    skew = '{2, 2, 6, 0, 11, 3, 3, 8};
    run_good("R9");

    // R6: a selected lane never valid gives timeout
    lane_live[2] = 1'b0;
    start_sync();
    settle();
    check(sync_done === 1'b0 && align_err === 1'b0, "R6", {sync_done, align_err}, 0);
    repeat (TMO) @(negedge clk);
    check(align_err === 1'b1, "R6", align_err, 1);
    repeat (5) @(negedge clk);
    check(align_err === 1'b1, "R6", align_err, 1);
    lane_live[2] = 1'b1;

    // R8: unselected lane with a far larger skew is ignored
    lane_en = 8'b1101_1111;
    skew = '{1, 4, 0, 9, 6, 30, 2, 7};
    run_good("R8");

    // R3 random rounds
    for (int r = 0; r < 6; r++) begin
      lane_en = N'($urandom_range(1, (1 << N) - 1));
      for (int i = 0; i < N; i++) skew[i] = $urandom_range(0, DEP - 1);
      run_good("R3");
    end

    summary();
  end
endmodule